// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Deferred Reload

This block generates four independent pulse-width modulated outputs. A simple 32-bit register bus configures it: one request per cycle, with valid, write, byte address and write data, and a ready and read data returned one cycle later. Each channel has a high-time value and a period value, both counted in cycles of the block clock. In every period the output is high for the high-time count and then low for the rest of the period.

Bus writes land in a shadow pair for each channel, and reads return those shadow values. A running channel copies its whole shadow pair into its active pair only on the last clock of the period in progress, so the period that is running is never shortened or reshaped. A channel whose shadow pair is all zero at that boundary stops, and its output is held high. A stopped channel loads any nonzero shadow pair on the next clock and starts a fresh period.

Each channel is a small state machine with the states CH_IDLE (stopped, output high), CH_HIGH (inside a period, output high) and CH_LOW (inside a period, output low). The transitions are START (CH_IDLE to CH_HIGH or CH_LOW when the shadow pair becomes nonzero), FALL (CH_HIGH to CH_LOW when the position count reaches the high time), RELOAD (the last cycle of a period back to CH_HIGH or CH_LOW with the shadow pair), HALT (the last cycle of a period to CH_IDLE when the shadow pair is zero) and HOLD (stay in the same state and advance the position count).

Top module: `pwm_quad`

## Requirements
- R1: Channel c (0 to 3) has its high-time register at byte offset 8*c and its period register at 8*c+4. Address bit 2 selects the period register, and address bits 7..3 select the channel.
- R2: A read returns the full 32-bit value most recently written to that register. bus_ready is high in the cycle after each request and is low otherwise, and a read's data is valid in that same cycle.
- R3: After reset every register reads 0 and all four outputs are high.
- R4: While a channel runs, each period lasts the period count in cycles. The output is high for the first high-time cycles of the period and low for the rest.
- R5: A nonzero period with a zero high time gives an output that is low for the whole period. A high time greater than or equal to the period gives an output that is high for the whole period. A zero period with a nonzero high time counts as a one-cycle period, with the output high.
- R6: If the shadow pair is all zero at the last cycle of a period, the channel stops and its output stays high until a nonzero value is written.
- R7: A write to a running channel changes nothing until the period in progress ends. Both shadow values are then taken at the same boundary.
- R8: When a channel is stopped and the clock edge that captures a write makes its shadow pair nonzero, the output still shows the stopped level after that edge. The next edge loads the pair and starts position 0 of a period.
- R9: Offsets that are not 4-byte aligned, and offsets of 0x20 and above, are unmapped. A write to one changes no register and no output. A read from one returns 0. Both complete with ready one cycle later.
- R10: Each channel's output depends only on its own registers. A stopped channel stays high while the others run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it also sets the unit of the counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access complete, one cycle after bus_valid |
| bus_rdata | output | 32 | Read data, valid with bus_ready on a read |
| pwm_out | output | 4 | One waveform per channel, bit c for channel c |

## Verification
The bench rewrites a running channel partway through a period and checks that the output keeps the old shape until the boundary. A design that applied writes at once would change the output early. It also checks the exact edge on which a stopped channel starts: a design that loaded on the write edge would go low one cycle early, and one that added an extra stage would go low one cycle late. Zero high time, high time at or above the period, and a zero period with a nonzero high time are driven on purpose, because off-by-one compares show up there as a stray high or low cycle. Aligned and unaligned unmapped offsets are written and read back, so a design that decoded only part of the address would corrupt a live register or return stale data.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    // Per-channel waveform state
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,   // stopped, output held high
        CH_HIGH = 2'd1,   // inside a period, high phase
        CH_LOW  = 2'd2    // inside a period, low phase
    } ch_state_e;

    // Register stride per channel is 8 bytes: high time at +0, period at +4
    localparam int unsigned CH_STRIDE_LOG2 = 3;
    localparam int unsigned SEL_BIT        = 2;

endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_valid,
    input  logic                           bus_write,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic                           bus_ready,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic [NUM_CH-1:0][DATA_W-1:0]  sh_hi,
    output logic [NUM_CH-1:0][DATA_W-1:0]  sh_per
);

    localparam int unsigned IDX_W = ADDR_W - CH_STRIDE_LOG2;

    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic              sel_per;
    logic [DATA_W-1:0] rd_mux;

    assign idx     = bus_addr[ADDR_W-1:CH_STRIDE_LOG2];
    assign sel_per = bus_addr[SEL_BIT];
    assign hit     = (bus_addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_CH));

    // Shadow registers, one pair per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_shadow
        logic wr_sel;
        assign wr_sel = bus_valid && bus_write && hit && (idx == IDX_W'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_hi[c]  <= '0;
                sh_per[c] <= '0;
            end else if (wr_sel) begin
                if (sel_per) sh_per[c] <= bus_wdata;
                else         sh_hi[c]  <= bus_wdata;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (idx == IDX_W'(c)) rd_mux = sel_per ? sh_per[c] : sh_hi[c];
        end
    end

    // One-cycle response for every access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_valid;
            bus_rdata <= (bus_valid && !bus_write && hit) ? rd_mux : '0;
        end
    end

    assert_ready_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> bus_ready);
    assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !bus_ready);
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !hit) |=> (bus_rdata == '0));

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
    import pwm_quad_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sh_hi,
    input  logic [DATA_W-1:0] sh_per,
    output logic              pwm_o
);

    ch_state_e         st, st_n;
    logic [DATA_W-1:0] cnt, cnt_n;
    logic [DATA_W-1:0] act_hi, act_per, hi_n, per_n;
    logic [DATA_W:0]   cnt_inc;
    logic              last;
    logic              sh_zero;

    assign sh_zero = (sh_hi == '0) && (sh_per == '0);
    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign last    = (cnt_inc >= {1'b0, act_per});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= CH_IDLE;
            cnt     <= '0;
            act_hi  <= '0;
            act_per <= '0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            act_hi  <= hi_n;
            act_per <= per_n;
        end
    end

    // Next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        hi_n  = act_hi;
        per_n = act_per;
        unique case (st)
            CH_IDLE: begin
                if (!sh_zero) begin                          // START
                    hi_n  = sh_hi;
                    per_n = sh_per;
                    cnt_n = '0;
                    st_n  = (sh_hi != '0) ? CH_HIGH : CH_LOW;
                end
            end
            CH_HIGH, CH_LOW: begin
                if (last) begin                              // RELOAD or HALT
                    hi_n  = sh_hi;
                    per_n = sh_per;
                    cnt_n = '0;
                    if (sh_zero)             st_n = CH_IDLE;
                    else if (sh_hi != '0)    st_n = CH_HIGH;
                    else                     st_n = CH_LOW;
                end else begin                               // HOLD or FALL
                    cnt_n = cnt_inc[DATA_W-1:0];
                    st_n  = (cnt_inc[DATA_W-1:0] < act_hi) ? CH_HIGH : CH_LOW;
                end
            end
            default: st_n = CH_IDLE;
        endcase
    end

    // Output
    always_comb begin
        pwm_o = (st != CH_LOW);
    end

    assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st != CH_IDLE && act_per != '0) |-> (cnt < act_per));
    assert_hold_mid_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != CH_IDLE && !last) |=> ($stable(act_hi) && $stable(act_per)));
    assert_idle_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_IDLE) |-> (act_hi == '0 && act_per == '0 && pwm_o));
    assert_zero_high_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st != CH_IDLE && act_hi == '0) |-> !pwm_o);
    assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st != CH_IDLE && act_hi >= act_per) |-> pwm_o);

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0][DATA_W-1:0] sh_hi;
    logic [NUM_CH-1:0][DATA_W-1:0] sh_per;

    pwm_quad_regs #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .sh_hi     (sh_hi),
        .sh_per    (sh_per)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pwm_quad_chan #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .sh_hi  (sh_hi[c]),
            .sh_per (sh_per[c]),
            .pwm_o  (pwm_out[c])
        );
    end

endmodule

// File: tb/pwm_quad_tb.sv
`timescale 1ns/1ps
module pwm_quad_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    always #2 clk = ~clk;   // 250 MHz

    pwm_quad u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model built from the requirements
    logic [31:0] m_sh_hi [4];
    logic [31:0] m_sh_per[4];
    logic [31:0] m_hi    [4];
    logic [31:0] m_per   [4];
    logic [31:0] m_pos   [4];
    bit          m_run   [4];
    bit          m_rdy;
    bit          m_rd;
    logic [31:0] m_rdata;

    function automatic bit is_mapped(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a < 8'h20);
    endfunction

    function automatic bit exp_out(input int c);
        return !m_run[c] || (m_pos[c] < m_hi[c]);
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_sh_hi[c] = '0; m_sh_per[c] = '0; m_hi[c] = '0;
            m_per[c] = '0; m_pos[c] = '0; m_run[c] = 1'b0;
        end
        m_rdy = 1'b0; m_rd = 1'b0; m_rdata = '0;
    endtask

    task automatic model_step(input bit v, input bit w, input logic [7:0] a,
                              input logic [31:0] d);
        for (int c = 0; c < 4; c++) begin
            bit zero_sh;
            zero_sh = (m_sh_hi[c] == 0) && (m_sh_per[c] == 0);
            if (!m_run[c]) begin
                if (!zero_sh) begin
                    m_hi[c] = m_sh_hi[c]; m_per[c] = m_sh_per[c];
                    m_pos[c] = 0; m_run[c] = 1'b1;
                end
            end else if ({1'b0, m_pos[c]} + 33'd1 >= {1'b0, m_per[c]}) begin
                m_hi[c] = m_sh_hi[c]; m_per[c] = m_sh_per[c]; m_pos[c] = 0;
                if (zero_sh) m_run[c] = 1'b0;
            end else begin
                m_pos[c] = m_pos[c] + 1;
            end
        end
        m_rdy = v;
        m_rd  = v && !w;
        m_rdata = '0;
        if (v && !w && is_mapped(a))
            m_rdata = a[2] ? m_sh_per[a[4:3]] : m_sh_hi[a[4:3]];
        if (v && w && is_mapped(a)) begin
            if (a[2]) m_sh_per[a[4:3]] = d;
            else      m_sh_hi[a[4:3]]  = d;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(bus_ready == m_rdy, "R2 ready", 32'(bus_ready), 32'(m_rdy));
        if (m_rd) chk(bus_rdata == m_rdata, "R2 read data", bus_rdata, m_rdata);
        for (int c = 0; c < 4; c++) begin
            string tag;
            if (!m_run[c])                tag = "R6 stopped output";
            else if (m_hi[c] == 0)        tag = "R5 zero high time";
            else if (m_hi[c] >= m_per[c]) tag = "R5 full high";
            else                          tag = "R4 waveform";
            chk(pwm_out[c] == exp_out(c), tag, 32'(pwm_out[c]), 32'(exp_out(c)));
        end
    endtask

    task automatic tick(input bit v, input bit w, input logic [7:0] a,
                        input logic [31:0] d);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        model_step(v, w, a, d);
        bus_valid = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        tick(1'b1, 1'b1, a, d);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        tick(1'b1, 1'b0, a, 32'h0);
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic count_high(input int ch, input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            idle(1);
            highs += int'(pwm_out[ch]);
        end
    endtask

    initial begin
        int highs;
        void'($urandom(32'd20240517));
        model_reset();
        repeat (3) @(negedge clk);
        // R3: reset state
        chk(pwm_out == 4'hF, "R3 outputs high in reset", 32'(pwm_out), 32'hF);
        chk(bus_ready == 1'b0, "R3 ready low in reset", 32'(bus_ready), 32'h0);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            rd_chk(8'(8 * c),     32'h0, "R3 high-time reads 0");
            rd_chk(8'(8 * c + 4), 32'h0, "R3 period reads 0");
        end

        // R1 / R2: map and readback
        for (int c = 0; c < 4; c++) wr(8'(8 * c), 32'hC3C3_5A50 | 32'(c));
        for (int c = 0; c < 4; c++) begin
            rd_chk(8'(8 * c),     32'hC3C3_5A50 | 32'(c), "R1 high-time offset");
            rd_chk(8'(8 * c + 4), 32'h0,                  "R1 period offset distinct");
        end
        for (int c = 0; c < 4; c++) wr(8'(8 * c), 32'h0);
        idle(3);
        chk(pwm_out == 4'hF, "R6 all stopped high", 32'(pwm_out), 32'hF);

        // R8 start timing and R7 deferral on channel 0
        wr(8'h04, 32'd5);
        chk(pwm_out[0] == 1'b1, "R8 no start on write edge", 32'(pwm_out[0]), 32'h1);
        idle(1);
        chk(pwm_out[0] == 1'b0, "R8 period starts after load", 32'(pwm_out[0]), 32'h0);
        wr(8'h00, 32'd5);
        chk(pwm_out[0] == 1'b0, "R7 write deferred", 32'(pwm_out[0]), 32'h0);
        for (int i = 0; i < 3; i++) begin
            idle(1);
            chk(pwm_out[0] == 1'b0, "R7 old period kept", 32'(pwm_out[0]), 32'h0);
        end
        idle(1);
        chk(pwm_out[0] == 1'b1, "R7 new values at boundary", 32'(pwm_out[0]), 32'h1);

        // R4 and R10 on channel 1
        wr(8'h0C, 32'd6);
        wr(8'h08, 32'd3);
        idle(8);
        chk(pwm_out[3] == 1'b1, "R10 idle channel unaffected", 32'(pwm_out[3]), 32'h1);
        count_high(1, 12, highs);
        chk(highs == 6, "R4 high count over two periods", 32'(highs), 32'd6);

        // R5 on channels 2 and 3
        wr(8'h10, 32'd9);
        wr(8'h14, 32'd4);
        wr(8'h1C, 32'd5);
        idle(10);
        count_high(2, 12, highs);
        chk(highs == 12, "R5 high time above period", 32'(highs), 32'd12);
        count_high(3, 10, highs);
        chk(highs == 0, "R5 zero high time", 32'(highs), 32'd0);

        // R6 stop channel 1
        wr(8'h08, 32'd0);
        wr(8'h0C, 32'd0);
        idle(8);
        count_high(1, 8, highs);
        chk(highs == 8, "R6 stopped channel held high", 32'(highs), 32'd8);
        rd_chk(8'h08, 32'h0, "R6 high-time cleared");
        rd_chk(8'h0C, 32'h0, "R6 period cleared");

        // R9 unmapped offsets
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h0D, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd_chk(8'h20, 32'h0, "R9 unmapped read 0x20");
        rd_chk(8'h02, 32'h0, "R9 unaligned read");
        rd_chk(8'hFC, 32'h0, "R9 unmapped read 0xFC");
        rd_chk(8'h00, 32'd5, "R9 mapped high-time untouched");
        rd_chk(8'h0C, 32'h0, "R9 mapped period untouched");
        idle(4);
        chk(pwm_out[1] == 1'b1, "R9 stopped channel still high", 32'(pwm_out[1]), 32'h1);

        // Constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int sel;
            sel = int'($urandom_range(0, 99));
            if (sel < 18) begin
                logic [7:0]  a;
                logic [31:0] d;
                a = 8'($urandom_range(0, 7) * 4);
                d = a[2] ? 32'($urandom_range(0, 20)) : 32'($urandom_range(0, 24));
                if ($urandom_range(0, 9) == 0) d = 32'h0;
                wr(a, d);
            end else if (sel < 28) begin
                logic [7:0] a;
                a = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                                : 8'($urandom_range(0, 7) * 4);
                tick(1'b1, 1'b0, a, 32'h0);
            end else if (sel < 31) begin
                wr(8'($urandom_range(32, 255)), $urandom());
            end else begin
                idle(1);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule